// File: doc/BRIEF.md
# Microcode Load Command Engine

This block carries out one command from a stream of 32-bit words: load a run of instructions into the instruction memory of a vector unit. The command word gives a pair count and a destination entry index. The operand words follow it in the stream. Each instruction is built from two consecutive operand words and fills one 64-bit memory entry. A tracking-table entry at the same index records where that instruction came from.

Before it moves any data, the engine checks three things in a fixed order. First, the command must sit at an odd word slot of its 128-bit group, so that the operands begin on a 64-bit boundary. Second, the destination run must fit inside the memory. Third, the stream must already hold every operand word. After these checks the engine waits for the vector unit to go idle, which acts as an implied flush. It then pops one operand word per clock and writes one entry every second clock. When the run ends, it reports how many stream words the command used.

Top module: `mpg_loader`

## Requirements
- R1: After reset, status is IDLE (0), and done, op_pop, imem_we and trk_we are all low.
- R2: Command word layout: count in bits 23:16, destination index in bits 15:0. A command whose cmd_pos is 0 or 2 finishes at once with err_align and done both high and adv = 1. It pops nothing and writes nothing.
- R3: A count field of 0 loads 256 pairs.
- R4: If cmd_pos is odd, the range is valid and avail is below twice the pair count, status reads WAIT (1). The engine pops nothing and writes nothing until enough words are present.
- R5: If the operands are present but vu_busy is high, status reads STALL (2). The engine pops nothing, and retries on each clock until vu_busy drops.
- R6: Pair i is written to entry index + i, in increasing order, with one write every second clock.
- R7: For each pair, imem_wdata[31:0] holds the second stream word (the vector half) and imem_wdata[63:32] holds the first stream word (the scalar half).
- R8: Each entry write is paired with a tracking write at the same index. Its data is the op_src value that came with the first word of the pair.
- R9: When the last pair is written, done pulses for one clock with adv = 1 + 2 × pairs, and status returns to IDLE.
- R10: If index + pairs is greater than DEPTH, the command finishes with err_range, done and adv = 1. It writes nothing. Alignment is checked before range.
- R11: During a load, exactly 2 × pairs words are popped, one per clock. Status reads LOAD (3) while this happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A load command is at the head of the stream |
| cmd_word | input | 32 | Command word: count in 23:16, index in 15:0 |
| cmd_pos | input | 2 | Word slot of the command within its 128-bit group |
| avail | input | AVW | Operand words present after the command |
| vu_busy | input | 1 | Vector unit is running |
| op_data | input | 32 | Operand word at the stream head |
| op_src | input | 32 | Source address of the quadword that holds op_data |
| op_pop | output | 1 | Consume op_data on this clock |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | AW | Instruction memory entry index |
| imem_wdata | output | 64 | Instruction entry data |
| trk_we | output | 1 | Tracking table write enable |
| trk_addr | output | AW | Tracking table entry index |
| trk_wdata | output | 32 | Tracking table data |
| status | output | 2 | 0 IDLE, 1 WAIT, 2 STALL, 3 LOAD |
| done | output | 1 | Command finished, for one clock |
| adv | output | 10 | Stream words used by the finished command |
| err_align | output | 1 | Operand alignment error, valid with done |
| err_range | output | 1 | Destination range error, valid with done |

## Verification
The assertions watch the start and end of every load on every cycle:
- a load never begins while vu_busy is high, from an even slot, or with too few words present;
- done is a single-clock pulse;
- entry writes never fall on back-to-back clocks;
- the two error flags never appear without done, or together.

Only the bench scenarios can show:
- the word swap inside each entry;
- the tracking data and its source quadword;
- the 256-pair meaning of a zero count;
- the exact range boundary;
- the adv value;
- that WAIT and STALL appear only under the matching input conditions.

// File: rtl/mpg_loader.sv
module mpg_loader #(
  parameter int DEPTH = 1024,
  parameter int AVW = 10,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [31:0]    cmd_word,
  input  logic [1:0]     cmd_pos,
  input  logic [AVW-1:0] avail,
  input  logic           vu_busy,
  input  logic [31:0]    op_data,
  input  logic [31:0]    op_src,
  output logic           op_pop,
  output logic           imem_we,
  output logic [AW-1:0]  imem_addr,
  output logic [63:0]    imem_wdata,
  output logic           trk_we,
  output logic [AW-1:0]  trk_addr,
  output logic [31:0]    trk_wdata,
  output logic [1:0]     status,
  output logic           done,
  output logic [9:0]     adv,
  output logic           err_align,
  output logic           err_range
);

  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_STALL = 2'd2, S_LOAD = 2'd3;

  logic [1:0]    st;
  logic [AW-1:0] idx;
  logic [8:0]    left;
  logic          half;
  logic [31:0]   lo_q, lo_src_q;

  logic [8:0]  pairs;
  logic [16:0] end_sum;
  logic        range_bad, enough, go;

  assign pairs     = (cmd_word[23:16] == 8'd0) ? 9'd256 : {1'b0, cmd_word[23:16]};
  assign end_sum   = {1'b0, cmd_word[15:0]} + {8'd0, pairs};
  assign range_bad = end_sum > 17'(DEPTH);
  assign enough    = 11'(avail) >= {1'b0, pairs, 1'b0};
  assign go        = cmd_valid && !done && (st != S_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; left <= '0; half <= 1'b0;
      lo_q <= '0; lo_src_q <= '0;
      done <= 1'b0; adv <= '0; err_align <= 1'b0; err_range <= 1'b0;
    end else begin
      done <= 1'b0; err_align <= 1'b0; err_range <= 1'b0;
      if (st == S_LOAD) begin
        half <= ~half;
        if (!half) begin
          lo_q <= op_data;
          lo_src_q <= op_src;
        end else begin
          idx  <= idx + 1'b1;
          left <= left - 1'b1;
          if (left == 9'd1) begin
            st <= S_IDLE;
            done <= 1'b1;
          end
        end
      end else if (go) begin
        if (!cmd_pos[0]) begin
          done <= 1'b1; err_align <= 1'b1; adv <= 10'd1; st <= S_IDLE;
        end else if (range_bad) begin
          done <= 1'b1; err_range <= 1'b1; adv <= 10'd1; st <= S_IDLE;
        end else if (!enough) begin
          st <= S_WAIT;
        end else if (vu_busy) begin
          st <= S_STALL;
        end else begin
          st   <= S_LOAD;
          idx  <= cmd_word[AW-1:0];
          left <= pairs;
          half <= 1'b0;
          adv  <= {pairs, 1'b1};
        end
      end else begin
        st <= S_IDLE;
      end
    end
  end

  assign op_pop     = (st == S_LOAD);
  assign imem_we    = (st == S_LOAD) && half;
  assign imem_addr  = idx;
  assign imem_wdata = {lo_q, op_data};
  assign trk_we     = imem_we;
  assign trk_addr   = idx;
  assign trk_wdata  = lo_src_q;
  assign status     = st;

  p_no_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status == S_LOAD) |-> !$past(vu_busy));

  p_aligned_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status == S_LOAD) |-> $past(cmd_pos[0]));

  p_words_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status == S_LOAD) |-> (11'($past(avail)) >= {1'b0, $past(pairs), 1'b0}));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_write_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |=> !imem_we);

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_align || err_range) |-> (done && !(err_align && err_range)));

endmodule

// File: tb/mpg_loader_tb.sv
module mpg_loader_tb;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, vu_busy = 1'b0;
  logic [31:0] cmd_word = '0, op_data = '0, op_src = '0;
  logic [1:0] cmd_pos = '0;
  logic [9:0] avail = '0;
  logic op_pop, imem_we, trk_we, done, err_align, err_range;
  logic [AW-1:0] imem_addr, trk_addr;
  logic [63:0] imem_wdata;
  logic [31:0] trk_wdata;
  logic [1:0] status;
  logic [9:0] adv;

  int errors = 0, checks = 0;
  logic [31:0] w [0:512];
  logic [31:0] ws [0:512];

  always #4 clk = ~clk;

  mpg_loader #(.DEPTH(DEPTH), .AVW(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_pos(cmd_pos), .avail(avail), .vu_busy(vu_busy), .op_data(op_data),
    .op_src(op_src), .op_pop(op_pop), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .trk_we(trk_we), .trk_addr(trk_addr),
    .trk_wdata(trk_wdata), .status(status), .done(done), .adv(adv),
    .err_align(err_align), .err_range(err_range));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pairs(input logic [7:0] c);
    return (c == 8'd0) ? 256 : int'(c);
  endfunction

  task automatic run(input logic [1:0] pos, input logic [7:0] cnt, input logic [15:0] imm,
                     input int short_n, input int busy_n);
    int pairs, need, head, wr_n, pops, bad_addr, bad_data, bad_trk, gate_bad;
    bit align_e, range_e, ok, prev_pop, prev_block, saw_wait, saw_stall, seen;
    logic [31:0] qbase;
    logic [9:0] adv_s;
    bit ea_s, er_s;
    pairs = exp_pairs(cnt);
    need = 2 * pairs;
    align_e = !pos[0];
    range_e = !align_e && (int'(imm) + pairs > DEPTH);
    ok = !align_e && !range_e;
    qbase = $urandom & 32'hFFFF_FFF0;
    for (int k = 0; k < 513; k++) begin
      w[k] = $urandom;
      ws[k] = qbase + 32'(16 * ((int'(pos) + 1 + k) >> 2));
    end
    head = 0; wr_n = 0; pops = 0; bad_addr = 0; bad_data = 0; bad_trk = 0; gate_bad = 0;
    prev_pop = 0; prev_block = 0; saw_wait = 0; saw_stall = 0; seen = 0;
    adv_s = '0; ea_s = 0; er_s = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (prev_pop) head++;
      cmd_valid = 1'b1;
      cmd_word = {8'h4A, cnt, imm};
      cmd_pos = pos;
      avail = (c < short_n) ? 10'(need - 1) : 10'(need);
      vu_busy = (c >= short_n) && (c < short_n + busy_n);
      op_data = w[head];
      op_src = ws[head];
      #1;
      if (status == 2'd1) saw_wait = 1;
      if (status == 2'd2) saw_stall = 1;
      if (prev_block && (op_pop || imem_we)) gate_bad++;
      if (op_pop) pops++;
      if (imem_we) begin
        if (int'(imem_addr) != int'(imm) + wr_n) bad_addr++;
        if (imem_wdata != {w[2*wr_n], w[2*wr_n+1]}) bad_data++;
        if (!trk_we || trk_addr != imem_addr || trk_wdata != ws[2*wr_n]) bad_trk++;
        wr_n++;
      end
      if (done) begin
        seen = 1; adv_s = adv; ea_s = err_align; er_s = err_range;
      end
      prev_pop = op_pop;
      prev_block = (c < short_n) || vu_busy;
    end
    @(negedge clk);
    cmd_valid = 1'b0; vu_busy = 1'b0;
    #1;
    chk(seen, "R9", "done seen", int'(seen), 1);
    chk(adv_s == (ok ? 10'(1 + need) : 10'd1), "R9", "adv", int'(adv_s), ok ? 1 + need : 1);
    chk(status == 2'd0, "R9", "status idle after done", int'(status), 0);
    chk(ea_s == align_e, "R2", "err_align", int'(ea_s), int'(align_e));
    chk(er_s == range_e, "R10", "err_range", int'(er_s), int'(range_e));
    chk(wr_n == (ok ? pairs : 0), "R3", "entry writes", wr_n, ok ? pairs : 0);
    chk(pops == (ok ? need : 0), "R11", "words popped", pops, ok ? need : 0);
    chk(bad_addr == 0, "R6", "address mismatches", bad_addr, 0);
    chk(bad_data == 0, "R7", "word order mismatches", bad_data, 0);
    chk(bad_trk == 0, "R8", "tracking mismatches", bad_trk, 0);
    chk(saw_wait == (ok && short_n > 0), "R4", "WAIT seen", int'(saw_wait), int'(ok && short_n > 0));
    chk(saw_stall == (ok && busy_n > 0), "R5", "STALL seen", int'(saw_stall), int'(ok && busy_n > 0));
    chk(gate_bad == 0, "R5", "activity while blocked", gate_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(status == 2'd0 && !done && !op_pop && !imem_we && !trk_we, "R1", "reset outputs",
        int'({status, done, op_pop, imem_we, trk_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd1, 8'd1, 16'd0, 0, 0);
    run(2'd3, 8'd0, 16'd0, 0, 0);
    run(2'd0, 8'd4, 16'd10, 0, 0);
    run(2'd2, 8'd4, 16'd10, 2, 0);
    run(2'd3, 8'd4, 16'(DEPTH - 4), 0, 0);
    run(2'd1, 8'd5, 16'(DEPTH - 4), 0, 0);
    run(2'd1, 8'd0, 16'd800, 0, 0);
    run(2'd0, 8'd0, 16'hFFFF, 0, 0);
    run(2'd3, 8'd7, 16'd100, 3, 4);
    run(2'd1, 8'd2, 16'd5, 0, 6);
    for (int t = 0; t < 20; t++) begin
      logic [7:0] cn;
      cn = ($urandom % 8 == 0) ? 8'd0 : 8'(1 + $urandom % 40);
      run(2'($urandom), cn, 16'($urandom % (DEPTH + 64)), int'($urandom % 4), int'($urandom % 4));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule